// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is a single channel of a 16-bit timer. It watches a free-running counter that is supplied from outside. Software reaches it through an 8-bit register bus. A two-bit mode field chooses between two modes.

In capture mode, a qualified edge on the input pin stores the counter value. In compare mode, a match between the counter and a stored value drives an action on the output pin. Either kind of event sets one sticky flag.

The 16-bit value moves over the bus as two separate bytes. An access to the high byte opens a lock, and the matching access to the low byte closes it. While a read lock is open, a capture cannot replace the byte pair that software is reading. While a write lock is open, a half-written compare value cannot cause a match. The value register has no reset, so its contents are undefined until the first write or capture.

Top module: `tmr_chan`

## Requirements
- R1: After reset, pin_o is 0, the flag is 0, and the control register reads 0x00.
- R2: Address 0 is the control register and reads back what was written. Bits 1:0 are the mode: 00 selects capture and any other value selects compare. Bits 3:2 are the edge select: 01 rising, 10 falling, 11 both, 00 none. Bits 5:4 are the match action: 01 toggle, 10 clear, 11 set, 00 none.
- R3: Address 2 holds value bits 15:8 and address 3 holds bits 7:0. Both are writable and readable.
- R4: The pin passes through a two-flop synchroniser. A capture stores the counter value present at the third rising clock edge after pin_i changes, and it sets the flag. The flag reads as bit 0 of address 1.
- R5: The selected edge or edges cause a capture. Edges that are not selected, and every edge when the select field is 00, leave the value unchanged.
- R6: In capture mode, a read of address 2 blocks captures until address 3 is read. A blocked capture is lost and does not set the flag. Captures resume once address 3 has been read.
- R7: In compare mode, a match between cnt_i and the value applies the selected action to pin_o at the next edge and sets the flag.
- R8: In compare mode, a write to address 2 suppresses all matches until address 3 is written. This covers matches against the old value and against the half-updated value. After the address 3 write, matches use the full new value.
- R9: Writing 1 to bit 0 of address 1 clears the flag. Writing 0 there leaves the flag unchanged.
- R10: In capture mode, pin_o holds its value even when cnt_i equals the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 16 | Free-running counter value |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (drives lock behaviour) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| pin_i | input | 1 | Capture input pin (asynchronous) |
| pin_o | output | 1 | Compare output pin |
| flag_o | output | 1 | Sticky event flag |

## Verification
The bench changes the counter on every cycle around an input edge. A design with the wrong synchroniser depth would therefore capture a neighbouring counter value. The bench also sends edges while a read lock is open. A design that ignored the lock would return a low byte that does not belong with the high byte, or would set the flag.

In compare mode, the bench writes only the high byte and then presents both the old value and the half-updated value on the counter. A design that lacked the write lock would toggle the pin on one of them. The bench also checks that edges which are not selected, a write of 0 to the flag, and a counter match in capture mode all leave the outputs unchanged.

// File: rtl/tmr_chan.sv
module tmr_chan (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cnt_i,
  input  logic [1:0]  addr_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic        pin_i,
  output logic        pin_o,
  output logic        flag_o
);
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_HI = 2'd2, A_LO = 2'd3;

  logic [5:0]  ctrl;
  logic [15:0] val;
  logic [2:0]  sy;
  logic        rlock, wlock;

  wire [1:0] mode = ctrl[1:0];
  wire [1:0] edg  = ctrl[3:2];
  wire [1:0] act  = ctrl[5:4];
  wire cmp   = |mode;
  wire rd_hi = rd_i && addr_i == A_HI;
  wire rd_lo = rd_i && addr_i == A_LO;
  wire wr_hi = wr_i && addr_i == A_HI;
  wire wr_lo = wr_i && addr_i == A_LO;
  wire rise  = sy[1] & ~sy[2];
  wire fall  = ~sy[1] & sy[2];
  wire capture = !cmp && !rlock && ((edg[0] && rise) || (edg[1] && fall));
  wire match   = cmp && !wlock && cnt_i == val;

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = {2'b00, ctrl};
      A_STAT:  rdata_o = {7'd0, flag_o};
      A_HI:    rdata_o = val[15:8];
      default: rdata_o = val[7:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sy <= '0;
    else        sy <= {sy[1:0], pin_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        ctrl <= '0;
    else if (wr_i && addr_i == A_CTRL) ctrl <= wdata_i[5:0];

  always_ff @(posedge clk) begin
    if (wr_hi)   val[15:8] <= wdata_i;
    if (wr_lo)   val[7:0]  <= wdata_i;
    if (capture) val       <= cnt_i;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rlock <= 1'b0;
      wlock <= 1'b0;
    end else begin
      if (cmp || rd_lo) rlock <= 1'b0;
      else if (rd_hi)   rlock <= 1'b1;
      if (!cmp || wr_lo) wlock <= 1'b0;
      else if (wr_hi)    wlock <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                          flag_o <= 1'b0;
    else if (capture || match)                           flag_o <= 1'b1;
    else if (wr_i && addr_i == A_STAT && wdata_i[0])     flag_o <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_o <= 1'b0;
    else if (match)
      case (act)
        2'b01:   pin_o <= ~pin_o;
        2'b10:   pin_o <= 1'b0;
        2'b11:   pin_o <= 1'b1;
        default: pin_o <= pin_o;
      endcase
endmodule

module tmr_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_i,
  input logic        wr_i,
  input logic [1:0]  addr_i,
  input logic        pin_o,
  input logic        flag_o,
  input logic        cmp,
  input logic        rlock,
  input logic        wlock,
  input logic [15:0] val
);
  // R10
  cap_pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp |=> $stable(pin_o));
  // R8
  wlock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp && wlock) |=> $stable(pin_o));
  // R6
  rlock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rlock && !(wr_i && addr_i[1])) |=> $stable(val));
  // R6
  rlock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i == 2'd2 && !cmp) |=> rlock);
  // R7
  pin_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_o) |-> flag_o);
endmodule

bind tmr_chan tmr_chan_chk chk (
  .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i),
  .pin_o(pin_o), .flag_o(flag_o), .cmp(cmp), .rlock(rlock), .wlock(wlock),
  .val(val)
);

// File: tb/tmr_chan_test.sv
module tmr_chan_test;
  logic        clk = 0, rst_n = 0;
  logic [15:0] cnt = 0;
  logic [1:0]  addr = 0;
  logic        wr = 0, rd = 0, pin = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata;
  logic        pin_o, flag_o;

  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];
  logic [15:0] act_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  tmr_chan uut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin), .pin_o(pin_o), .flag_o(flag_o)
  );

  always @(negedge clk or posedge clk) begin
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      logic [15:0] e, a;
      string t;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  task automatic expect_item(string t, logic [15:0] e);
    tag_q.push_back(t);
    exp_q.push_back(e);
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic bus_rd(logic [1:0] a, string t, logic [7:0] e);
    @(negedge clk);
    addr = a; rd = 1;
    expect_item(t, {8'd0, e});
    #5 act_q.push_back({8'd0, rdata});
    @(negedge clk);
    rd = 0;
  endtask

  task automatic port_chk(string t, logic e, logic a);
    expect_item(t, {15'd0, e});
    act_q.push_back({15'd0, a});
  endtask

  task automatic pin_edge(logic v, logic [15:0] c);
    @(negedge clk);
    pin = v; cnt = c;
    repeat (4) @(negedge clk);
  endtask

  task automatic cnt_pulse(logic [15:0] v);
    @(negedge clk);
    cnt = v;
    @(negedge clk);
    cnt = 16'd0;
    #2;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    port_chk("R1 pin_o", 1'b0, pin_o);
    port_chk("R1 flag", 1'b0, flag_o);
    bus_rd(2'd0, "R1 ctrl", 8'h00);

    bus_wr(2'd0, 8'h04);
    bus_rd(2'd0, "R2 ctrl readback", 8'h04);

    // R4 latency: counter changes every cycle, third edge value captured
    @(negedge clk); pin = 1; cnt = 16'h1111;
    @(negedge clk); cnt = 16'h2222;
    @(negedge clk); cnt = 16'h3A5C;
    @(negedge clk); cnt = 16'h4444;
    @(negedge clk);
    bus_rd(2'd2, "R4 capture hi", 8'h3A);
    bus_rd(2'd3, "R4 capture lo", 8'h5C);
    bus_rd(2'd1, "R4 flag", 8'h01);

    bus_wr(2'd1, 8'h00);
    bus_rd(2'd1, "R9 write 0 keeps flag", 8'h01);
    bus_wr(2'd1, 8'h01);
    bus_rd(2'd1, "R9 write 1 clears", 8'h00);

    bus_rd(2'd2, "R6 lock hi", 8'h3A);
    pin_edge(0, 16'hBEEF);
    pin_edge(1, 16'hBEEF);
    bus_rd(2'd1, "R6 no flag while locked", 8'h00);
    bus_rd(2'd3, "R6 lo keeps old", 8'h5C);
    bus_rd(2'd2, "R6 hi keeps old", 8'h3A);
    bus_rd(2'd3, "R6 unlock", 8'h5C);
    pin_edge(0, 16'h7788);
    pin_edge(1, 16'h7788);
    bus_rd(2'd2, "R6 resumed hi", 8'h77);
    bus_rd(2'd3, "R6 resumed lo", 8'h88);

    bus_wr(2'd0, 8'h08);
    pin_edge(0, 16'h0102);
    bus_rd(2'd2, "R5 falling hi", 8'h01);
    bus_rd(2'd3, "R5 falling lo", 8'h02);
    pin_edge(1, 16'h0304);
    bus_rd(2'd2, "R5 rise ignored", 8'h01);
    bus_rd(2'd3, "R5 rise ignored lo", 8'h02);
    bus_wr(2'd0, 8'h0C);
    pin_edge(0, 16'h0506);
    bus_rd(2'd2, "R5 both fall", 8'h05);
    bus_rd(2'd3, "R5 both fall lo", 8'h06);
    pin_edge(1, 16'h0708);
    bus_rd(2'd2, "R5 both rise", 8'h07);
    bus_rd(2'd3, "R5 both rise lo", 8'h08);
    bus_wr(2'd0, 8'h00);
    pin_edge(0, 16'h0909);
    bus_rd(2'd2, "R5 none", 8'h07);
    bus_rd(2'd3, "R5 none lo", 8'h08);

    bus_wr(2'd0, 8'h30);
    @(negedge clk); cnt = 16'h0708;
    repeat (3) @(negedge clk);
    #2 port_chk("R10 capture mode pin hold", 1'b0, pin_o);
    cnt = 16'd0;

    bus_wr(2'd0, 8'h11);
    bus_wr(2'd1, 8'h01);
    bus_wr(2'd2, 8'h50);
    bus_wr(2'd3, 8'h00);
    bus_rd(2'd2, "R3 hi", 8'h50);
    bus_rd(2'd3, "R3 lo", 8'h00);
    cnt_pulse(16'h5000);
    port_chk("R7 toggle", 1'b1, pin_o);
    port_chk("R7 flag", 1'b1, flag_o);
    bus_wr(2'd0, 8'h21);
    cnt_pulse(16'h5000);
    port_chk("R7 clear", 1'b0, pin_o);
    bus_wr(2'd0, 8'h31);
    cnt_pulse(16'h5000);
    port_chk("R7 set", 1'b1, pin_o);
    cnt_pulse(16'h5000);
    port_chk("R7 set again", 1'b1, pin_o);

    bus_wr(2'd0, 8'h11);
    bus_wr(2'd1, 8'h01);
    bus_wr(2'd2, 8'h60);
    cnt_pulse(16'h6000);
    port_chk("R8 half value blocked", 1'b1, pin_o);
    port_chk("R8 no flag", 1'b0, flag_o);
    cnt_pulse(16'h5000);
    port_chk("R8 old value blocked", 1'b1, pin_o);
    bus_wr(2'd3, 8'h10);
    cnt_pulse(16'h6000);
    port_chk("R8 stale half no match", 1'b1, pin_o);
    cnt_pulse(16'h6010);
    port_chk("R8 new value match", 1'b0, pin_o);
    port_chk("R8 flag after match", 1'b1, flag_o);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d unmatched expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule